// File: doc/BRIEF.md
# Vector SHA-2 Sigma Function Unit

This unit takes a 128-bit vector and applies one of the SHA-2 sigma functions to every lane of it in a single pass. A width select splits the vector into four 32-bit lanes (SHA-256 functions) or two 64-bit lanes (SHA-512 functions). A one-bit family select picks the small sigma pair or the capital Sigma pair. A 4-bit mask then picks function 0 or function 1 separately in each lane, so one beat can mix, for example, sigma0 and sigma1 across lanes. It is meant to sit next to a message-schedule or round datapath that feeds it vectors and collects the results. Message scheduling, compression rounds and padding are not part of it.

Data moves on a valid/ready stream in and a valid/ready stream out, with one result register between them. A beat is taken when `s_valid` and `s_ready` are both high. The result for that beat is shown on the output in the next cycle with `m_valid` high. While `m_valid` is high and `m_ready` is low, the result holds steady and `s_ready` is low, so no input is lost. When `m_ready` is high, the held result leaves and a new beat may enter in the same cycle, giving one beat per cycle. The width, family and mask inputs travel with the data and are sampled in the same cycle as it.

Top module: `sha_sigma_unit`

## Requirements
- R1: With `s_wide`=0 the vector holds four 32-bit lanes; lane 0 is bits 127:96, lane 3 is bits 31:0, and lane i uses mask bit `s_sel[3-i]` (lane 0 uses the MSB).
- R2: With `s_big`=0 each 32-bit lane x gives ROTR7(x)^ROTR18(x)^SHR3(x) when its mask bit is 0 and ROTR17(x)^ROTR19(x)^SHR10(x) when it is 1.
- R3: With `s_big`=1 each 32-bit lane x gives ROTR2^ROTR13^ROTR22 of x when its mask bit is 0 and ROTR6^ROTR11^ROTR25 of x when it is 1.
- R4: With `s_wide`=1 the vector holds two 64-bit lanes; lane 0 is bits 127:64 and uses `s_sel[3]`, lane 1 is bits 63:0 and uses `s_sel[1]`; `s_sel[2]` and `s_sel[0]` have no effect on the result.
- R5: In 64-bit mode with `s_big`=0 a lane gives ROTR1^ROTR8^SHR7 (bit 0) or ROTR19^ROTR61^SHR6 (bit 1); with `s_big`=1 it gives ROTR28^ROTR34^ROTR39 (bit 0) or ROTR14^ROTR18^ROTR41 (bit 1).
- R6: A beat accepted at a clock edge appears on `m_data` with `m_valid` high right after that edge; with no beat accepted and the output taken, `m_valid` falls.
- R7: While `m_valid`=1 and `m_ready`=0, `m_data` and `m_valid` hold and `s_ready` is low.
- R8: When `m_ready`=1 a new beat is accepted in the same cycle as the held result leaves, so back-to-back beats pass at one per cycle.
- R9: After reset `m_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Unit can take a beat |
| s_data | input | 128 | Input vector |
| s_wide | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| s_big | input | 1 | 0: small sigma family, 1: capital Sigma family |
| s_sel | input | 4 | Per-lane function choice, bit 3 for lane 0 |
| m_valid | output | 1 | Result present |
| m_ready | input | 1 | Consumer takes the result |
| m_data | output | 128 | Result vector |

## Verification
The two functions that share a cycle are draining the held result and capturing the next beat: with `m_ready` high, one edge both hands over the old result and loads the new one. The bench provokes this with runs of back-to-back beats whose widths, families and masks change every cycle, and judges each output against a model in the cycle after its beat. It also stalls the output with a beat waiting, then releases it, and checks that the held result stays put, that the waiting beat is taken only on release, and that its result follows one cycle later.

// File: rtl/sigma_pkg.sv
package sigma_pkg;

  localparam int VEC_W  = 128;
  localparam int SEL_W  = 4;
  localparam int NARROW = 32;
  localparam int WIDE   = 64;

  // Three terms of one sigma function; the last term is a plain shift
  // when use_shr is set, otherwise a rotation.
  typedef struct packed {
    logic [6:0] a;
    logic [6:0] b;
    logic [6:0] c;
    logic       use_shr;
  } sig_amt_t;

  function automatic sig_amt_t amounts(input bit wide, input bit big, input bit pick);
    sig_amt_t t;
    case ({wide, big, pick})
      3'b000:  t = '{7'd7,  7'd18, 7'd3,  1'b1};
      3'b001:  t = '{7'd17, 7'd19, 7'd10, 1'b1};
      3'b010:  t = '{7'd2,  7'd13, 7'd22, 1'b0};
      3'b011:  t = '{7'd6,  7'd11, 7'd25, 1'b0};
      3'b100:  t = '{7'd1,  7'd8,  7'd7,  1'b1};
      3'b101:  t = '{7'd19, 7'd61, 7'd6,  1'b1};
      3'b110:  t = '{7'd28, 7'd34, 7'd39, 1'b0};
      default: t = '{7'd14, 7'd18, 7'd41, 1'b0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sigma_lane.sv
module sigma_lane
  import sigma_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic         big,
  input  logic         pick,
  output logic [W-1:0] y
);

  localparam bit IS_WIDE = (W == WIDE);

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int n);
    return (v >> n) | (v << (W - n));
  endfunction

  logic [W-1:0] f_s0, f_s1, f_l0, f_l1;

  // Each function has fixed amounts, so the rotations are wiring only.
  function automatic logic [W-1:0] eval(input logic [W-1:0] v, input sig_amt_t t);
    logic [W-1:0] last;
    last = t.use_shr ? (v >> int'(t.c)) : rotr(v, int'(t.c));
    return rotr(v, int'(t.a)) ^ rotr(v, int'(t.b)) ^ last;
  endfunction

  always_comb begin
    f_s0 = eval(x, amounts(IS_WIDE, 1'b0, 1'b0));
    f_s1 = eval(x, amounts(IS_WIDE, 1'b0, 1'b1));
    f_l0 = eval(x, amounts(IS_WIDE, 1'b1, 1'b0));
    f_l1 = eval(x, amounts(IS_WIDE, 1'b1, 1'b1));
    case ({big, pick})
      2'b00:   y = f_s0;
      2'b01:   y = f_s1;
      2'b10:   y = f_l0;
      default: y = f_l1;
    endcase
  end

  // R2/R3: a zero lane maps to zero in every function
  always_comb begin
    if (x == '0) assert_zero_maps_zero_R2: assert (y == '0);
  end

endmodule

// File: rtl/sha_sigma_unit.sv
module sha_sigma_unit
  import sigma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [VEC_W-1:0] s_data,
  input  logic             s_wide,
  input  logic             s_big,
  input  logic [SEL_W-1:0] s_sel,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [VEC_W-1:0] m_data
);

  localparam int N32 = VEC_W / NARROW;
  localparam int N64 = VEC_W / WIDE;

  logic [VEC_W-1:0] res32, res64, res_next;
  logic             take;

  // Lane 0 is the leftmost slice and uses the top mask bit.
  generate
    for (genvar i = 0; i < N32; i++) begin : g_narrow
      sigma_lane #(.W(NARROW)) u_lane (
        .x    (s_data[VEC_W-1-i*NARROW -: NARROW]),
        .big  (s_big),
        .pick (s_sel[SEL_W-1-i]),
        .y    (res32[VEC_W-1-i*NARROW -: NARROW])
      );
    end
    for (genvar j = 0; j < N64; j++) begin : g_wide
      sigma_lane #(.W(WIDE)) u_lane (
        .x    (s_data[VEC_W-1-j*WIDE -: WIDE]),
        .big  (s_big),
        .pick (s_sel[SEL_W-1-2*j]),
        .y    (res64[VEC_W-1-j*WIDE -: WIDE])
      );
    end
  endgenerate

  assign res_next = s_wide ? res64 : res32;
  assign s_ready  = !m_valid || m_ready;
  assign take     = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (take) begin
        m_valid <= 1'b1;
        m_data  <= res_next;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !s_valid |=> !m_valid);

  assert_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |-> s_ready);

endmodule

// File: tb/sim_sha_sigma_unit.sv
module sim_sha_sigma_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [127:0] s_data = '0;
  logic         s_wide = 1'b0;
  logic         s_big = 1'b0;
  logic [3:0]   s_sel = '0;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [127:0] m_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sha_sigma_unit u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_wide(s_wide), .s_big(s_big), .s_sel(s_sel),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  localparam logic [127:0] PATS [4] = '{
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h8000_0001_ffff_0000_5a5a_a5a5_dead_beef,
    128'hffff_ffff_ffff_ffff_0000_0000_0000_0001,
    128'h6a09_e667_bb67_ae85_3c6e_f372_a54f_f53a
  };

  function automatic logic [31:0] r32(input logic [31:0] v, input int n);
    return (v >> n) | (v << (32 - n));
  endfunction
  function automatic logic [63:0] r64(input logic [63:0] v, input int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic logic [31:0] f32(input logic [31:0] x, input bit big, input bit p);
    if (!big) return p ? (r32(x,17) ^ r32(x,19) ^ (x >> 10)) : (r32(x,7) ^ r32(x,18) ^ (x >> 3));
    return p ? (r32(x,6) ^ r32(x,11) ^ r32(x,25)) : (r32(x,2) ^ r32(x,13) ^ r32(x,22));
  endfunction
  function automatic logic [63:0] f64(input logic [63:0] x, input bit big, input bit p);
    if (!big) return p ? (r64(x,19) ^ r64(x,61) ^ (x >> 6)) : (r64(x,1) ^ r64(x,8) ^ (x >> 7));
    return p ? (r64(x,14) ^ r64(x,18) ^ r64(x,41)) : (r64(x,28) ^ r64(x,34) ^ r64(x,39));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] d, input bit wide,
                                         input bit big, input logic [3:0] sel);
    logic [127:0] r;
    r = '0;
    if (!wide) begin
      for (int i = 0; i < 4; i++)
        r[127-32*i -: 32] = f32(d[127-32*i -: 32], big, sel[3-i]);
    end else begin
      for (int i = 0; i < 2; i++)
        r[127-64*i -: 64] = f64(d[127-64*i -: 64], big, sel[3-2*i]);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One beat, sampled on the negedge after the capturing edge.
  task automatic one(input logic [127:0] d, input bit w, input bit b,
                     input logic [3:0] s, input string req);
    logic [127:0] e;
    e = model(d, w, b, s);
    s_valid = 1'b1; s_data = d; s_wide = w; s_big = b; s_sel = s; m_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0;
    chk(m_valid === 1'b1 && m_data === e, req, m_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] e1, e2, held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(m_valid === 1'b0, "R9 m_valid", {127'd0, m_valid}, 128'd0);
    chk(s_ready === 1'b1, "R9 s_ready", {127'd0, s_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Known answer: 32-bit small sigma0 of 1 is 0x02004000 (R2)
    one({96'd0, 32'd1}, 1'b0, 1'b0, 4'b0000, "R2 known");
    chk(m_data[31:0] === 32'h0200_4000, "R2 literal", {96'd0, m_data[31:0]}, 128'h0200_4000);

    // Table walk: every mask in both modes and both families (R1..R5)
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 16; m++) begin
        one(PATS[p], 1'b0, 1'b0, 4'(m), "R1/R2 narrow small");
        one(PATS[p], 1'b0, 1'b1, 4'(m), "R1/R3 narrow large");
        one(PATS[p], 1'b1, 1'b0, 4'(m), "R4/R5 wide small");
        one(PATS[p], 1'b1, 1'b1, 4'(m), "R4/R5 wide large");
      end

    // R4: odd mask bits ignored in 64-bit mode
    one(PATS[3], 1'b1, 1'b1, 4'b1010, "R4 base");
    held = m_data;
    one(PATS[3], 1'b1, 1'b1, 4'b1111, "R4 odd bits");
    chk(m_data === held, "R4 ignored bits", m_data, held);

    // R6: output drops when nothing is accepted
    @(negedge clk);
    chk(m_valid === 1'b0, "R6 drain", {127'd0, m_valid}, 128'd0);

    // R8: back-to-back beats with changing controls
    for (int k = 0; k < 8; k++) begin
      s_valid = 1'b1; m_ready = 1'b1;
      s_data = PATS[k % 4]; s_wide = k[0]; s_big = k[1]; s_sel = 4'(k * 5);
      e1 = model(s_data, s_wide, s_big, s_sel);
      @(posedge clk); @(negedge clk);
      chk(m_valid === 1'b1 && m_data === e1, "R8 streaming", m_data, e1);
      chk(s_ready === 1'b1, "R8 ready", {127'd0, s_ready}, 128'd1);
    end
    s_valid = 1'b0;
    @(negedge clk);

    // R7: stall with a waiting beat, then release (R8 overlap)
    e1 = model(PATS[0], 1'b0, 1'b1, 4'b0110);
    e2 = model(PATS[1], 1'b1, 1'b0, 4'b1000);
    s_valid = 1'b1; s_data = PATS[0]; s_wide = 1'b0; s_big = 1'b1; s_sel = 4'b0110;
    m_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    s_data = PATS[1]; s_wide = 1'b1; s_big = 1'b0; s_sel = 4'b1000;
    for (int k = 0; k < 3; k++) begin
      chk(s_ready === 1'b0, "R7 not ready", {127'd0, s_ready}, 128'd0);
      chk(m_valid === 1'b1 && m_data === e1, "R7 hold", m_data, e1);
      @(posedge clk); @(negedge clk);
    end
    m_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0;
    chk(m_valid === 1'b1 && m_data === e2, "R8 overlap", m_data, e2);
    @(posedge clk); @(negedge clk);
    chk(m_valid === 1'b0, "R6 empty", {127'd0, m_valid}, 128'd0);

    // R9: reset mid-stall clears the output
    s_valid = 1'b1; m_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(m_valid === 1'b0 && s_ready === 1'b1, "R9 re-reset", {126'd0, m_valid, s_ready}, 128'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule